// File: doc/BRIEF.md
# Eye-Opening Threshold Interrupt Controller

This block sits beside a four-channel serial receiver and watches the eye-quality figures that each channel's measurement logic reports. Every channel delivers an 8-bit horizontal opening, an 8-bit vertical opening and a one-cycle valid strobe. When a valid horizontal or vertical figure is strictly smaller than the limit programmed for that channel and axis, and the channel's enable is set, a sticky cause bit is recorded. The interrupt line goes active while any enabled channel holds a cause bit.

A small register port, standing in for the management bus, programs the enables and limits and reads back the cause bits. Cause bits are cleared by writing ones to them. The interrupt leaves the block as an active-low level together with a drive-enable, so that a pad can pull a shared line low and otherwise release it.

The line is driven by a two-state machine. QUIET releases the line. RAISED drives the line low. The transition QUIET to RAISED is taken on the clock edge after some enabled channel holds a cause bit. The transition RAISED to QUIET is taken on the clock edge after no enabled channel holds one.

Top module: `eye_irq_ctrl`

## Requirements
- R1: Each of the four channels has its own enable, which is bit c of register 0. A channel whose enable is clear records no cause, whatever its measurements are.
- R2: After reset, all enables, cause bits and limits read 0, `irq_n` is 1 and `irq_oe` is 0.
- R3: The horizontal limit of channel c is at address 4+2c and the vertical limit is at 5+2c. Each reads back the last value written to it.
- R4: When channel c is enabled, its valid bit is high and its horizontal value is below its horizontal limit, bit c of the horizontal cause register (address 1) is set. The bit reads 1 from the cycle after that strobe. Without the valid bit, nothing is recorded.
- R5: The same rule applies to the vertical value and limit, recorded in bit c of the vertical cause register (address 2).
- R6: A value equal to or above its limit records nothing. The comparison is unsigned.
- R7: Writing a 1 to a cause bit clears it. Bits written as 0, and the bits of the other cause register, are left unchanged.
- R8: `irq_n` goes to 0 and `irq_oe` to 1 one clock edge after an enabled channel first holds a cause bit.
- R9: The line is released one clock edge after the last cause bit of an enabled channel is cleared, or after that channel's enable is cleared. Clearing an enable leaves the channel's cause bits in place.
- R10: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R11: `irq_oe` is always the inverse of `irq_n`. The line is driven only low and is otherwise released, so that it can be shared as a wired-OR.
- R12: Reads are combinational. Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 4 | Per-channel measurement strobe |
| meas_h | input | 32 | Horizontal openings, channel c in bits 8c+7..8c |
| meas_v | input | 32 | Vertical openings, channel c in bits 8c+7..8c |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Pad drive-enable, high while the line is pulled low |

## Verification
A strobe presented before clock edge k sets its cause bit at edge k, so the bench reads the cause registers at the falling edge that follows. At that same falling edge it checks that the line is still released. The line follows one edge later, at edge k+1, so the bench checks it at the next falling edge. Clearing writes and enable changes are treated the same way: the line is checked as still driven right after the write edge, and as released one cycle later. The sweep covers every channel and axis with limits of 0, 1, 0x80 and 0xFF and values of one below, equal to and one above each limit, so that the strict comparison is checked at both ends of the range.

// File: rtl/eye_irq_pkg.sv
package eye_irq_pkg;

    // Register addresses; limits follow at LIM_BASE + 2*channel (+1 for vertical)
    localparam int ADDR_EN      = 0;
    localparam int ADDR_CAUSE_H = 1;
    localparam int ADDR_CAUSE_V = 2;
    localparam int LIM_BASE     = 4;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/eye_lim_regs.sv
module eye_lim_regs
    import eye_irq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [NCH-1:0]    cause_h,
    input  logic [NCH-1:0]    cause_v,
    output logic [DW-1:0]     reg_rdata,
    output logic [NCH-1:0]    en,
    output logic [NCH*DW-1:0] lim_h,
    output logic [NCH*DW-1:0] lim_v,
    output logic [NCH-1:0]    clr_h,
    output logic [NCH-1:0]    clr_v
);

    logic [NCH-1:0] en_q;
    logic           wr_en_reg;
    logic           wr_cause_h;
    logic           wr_cause_v;

    assign wr_en_reg  = reg_we && (reg_addr == AW'(ADDR_EN));
    assign wr_cause_h = reg_we && (reg_addr == AW'(ADDR_CAUSE_H));
    assign wr_cause_v = reg_we && (reg_addr == AW'(ADDR_CAUSE_V));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_reg) begin
            en_q <= reg_wdata[NCH-1:0];
        end
    end

    assign en    = en_q;
    assign clr_h = wr_cause_h ? reg_wdata[NCH-1:0] : '0;
    assign clr_v = wr_cause_v ? reg_wdata[NCH-1:0] : '0;

    logic [DW-1:0] lh_q [NCH];
    logic [DW-1:0] lv_q [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_lim
        localparam int AH = LIM_BASE + 2 * c;
        localparam int AV = LIM_BASE + 2 * c + 1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lh_q[c] <= '0;
                lv_q[c] <= '0;
            end else if (reg_we) begin
                if (reg_addr == AW'(AH)) lh_q[c] <= reg_wdata;
                if (reg_addr == AW'(AV)) lv_q[c] <= reg_wdata;
            end
        end

        assign lim_h[c*DW +: DW] = lh_q[c];
        assign lim_v[c*DW +: DW] = lv_q[c];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_EN))      reg_rdata = DW'(en_q);
        if (reg_addr == AW'(ADDR_CAUSE_H)) reg_rdata = DW'(cause_h);
        if (reg_addr == AW'(ADDR_CAUSE_V)) reg_rdata = DW'(cause_v);
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(LIM_BASE + 2 * c))     reg_rdata = lh_q[c];
            if (reg_addr == AW'(LIM_BASE + 2 * c + 1)) reg_rdata = lv_q[c];
        end
    end

endmodule

// File: rtl/eye_chan_mon.sv
module eye_chan_mon #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          valid,
    input  logic [DW-1:0] val_h,
    input  logic [DW-1:0] val_v,
    input  logic [DW-1:0] lim_h,
    input  logic [DW-1:0] lim_v,
    input  logic          clr_h,
    input  logic          clr_v,
    output logic          ev_h,
    output logic          ev_v,
    output logic          cause_h,
    output logic          cause_v
);

    // Strictly below the limit; equality is not an event
    assign ev_h = en && valid && (val_h < lim_h);
    assign ev_v = en && valid && (val_v < lim_v);

    // Set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_h <= 1'b0;
            cause_v <= 1'b0;
        end else begin
            cause_h <= ev_h || (cause_h && !clr_h);
            cause_v <= ev_v || (cause_v && !clr_v);
        end
    end

endmodule

// File: rtl/eye_irq_fsm.sv
module eye_irq_fsm
    import eye_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n,
    output logic irq_oe
);

    irq_state_t st_q;
    irq_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_QUIET:  if (pending)  st_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) st_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (st_q)
            IRQ_QUIET: begin
                irq_oe = 1'b0;
                irq_n  = 1'b1;
            end
            IRQ_RAISED: begin
                irq_oe = 1'b1;
                irq_n  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eye_irq_ctrl.sv
module eye_irq_ctrl #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    meas_valid,
    input  logic [NCH*DW-1:0] meas_h,
    input  logic [NCH*DW-1:0] meas_v,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_n,
    output logic              irq_oe
);

    logic [NCH-1:0]    en;
    logic [NCH*DW-1:0] lim_h;
    logic [NCH*DW-1:0] lim_v;
    logic [NCH-1:0]    clr_h;
    logic [NCH-1:0]    clr_v;
    logic [NCH-1:0]    ev_h;
    logic [NCH-1:0]    ev_v;
    logic [NCH-1:0]    cause_h;
    logic [NCH-1:0]    cause_v;
    logic              pending;

    eye_lim_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cause_h   (cause_h),
        .cause_v   (cause_v),
        .reg_rdata (reg_rdata),
        .en        (en),
        .lim_h     (lim_h),
        .lim_v     (lim_v),
        .clr_h     (clr_h),
        .clr_v     (clr_v)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        eye_chan_mon #(.DW(DW)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en[c]),
            .valid   (meas_valid[c]),
            .val_h   (meas_h[c*DW +: DW]),
            .val_v   (meas_v[c*DW +: DW]),
            .lim_h   (lim_h[c*DW +: DW]),
            .lim_v   (lim_v[c*DW +: DW]),
            .clr_h   (clr_h[c]),
            .clr_v   (clr_v[c]),
            .ev_h    (ev_h[c]),
            .ev_v    (ev_v[c]),
            .cause_h (cause_h[c]),
            .cause_v (cause_v[c])
        );
    end

    assign pending = |(en & (cause_h | cause_v));

    eye_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_n   (irq_n),
        .irq_oe  (irq_oe)
    );

endmodule

// File: rtl/eye_irq_chk.sv
module eye_irq_chk
    import eye_irq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [AW-1:0]  reg_addr,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] ev_h,
    input logic [NCH-1:0] cause_h,
    input logic [NCH-1:0] cause_v,
    input logic           pending,
    input logic           irq_n,
    input logic           irq_oe
);

    AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en == '0)); // R2

    AST_RAISE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !irq_n); // R8

    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> irq_n); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_h != '0) |=> ((cause_h & $past(ev_h)) == $past(ev_h))); // R10

    AST_HOLD_H: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == AW'(ADDR_CAUSE_H)))
        |=> ((cause_h & $past(cause_h)) == $past(cause_h))); // R7

    AST_HOLD_V: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == AW'(ADDR_CAUSE_V)))
        |=> ((cause_v & $past(cause_v)) == $past(cause_v))); // R7

    AST_PAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe != irq_n); // R11

endmodule

bind eye_irq_ctrl eye_irq_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .en       (en),
    .ev_h     (ev_h),
    .cause_h  (cause_h),
    .cause_v  (cause_v),
    .pending  (pending),
    .irq_n    (irq_n),
    .irq_oe   (irq_oe)
);

// File: tb/tb_eye_irq_ctrl.sv
module tb_eye_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    meas_valid;
    logic [NCH*DW-1:0] meas_h;
    logic [NCH*DW-1:0] meas_v;
    logic              reg_we;
    logic [AW-1:0]     reg_addr;
    logic [DW-1:0]     reg_wdata;
    logic [DW-1:0]     reg_rdata;
    logic              irq_n;
    logic              irq_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eye_irq_ctrl #(.NCH(NCH), .DW(DW), .AW(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_h     (meas_h),
        .meas_v     (meas_v),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_n      (irq_n),
        .irq_oe     (irq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] vm, input logic [NCH*DW-1:0] mh,
                         input logic [NCH*DW-1:0] mv);
        @(negedge clk);
        meas_valid = vm; meas_h = mh; meas_v = mv;
        @(negedge clk);
        meas_valid = '0;
    endtask

    task automatic pad(input string req, input logic asserted);
        chk(req, {31'd0, irq_n},  {31'd0, !asserted});
        chk(req, {31'd0, irq_oe}, {31'd0, asserted});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [7:0] lims [4];
        lims[0] = 8'h00; lims[1] = 8'h01; lims[2] = 8'h80; lims[3] = 8'hFF;

        rst_n = 1'b0; meas_valid = '0; meas_h = '0; meas_v = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(0, r); chk("R2 enables", r, 0);
        rd(1, r); chk("R2 cause_h", r, 0);
        rd(2, r); chk("R2 cause_v", r, 0);
        for (int a = 4; a < 12; a++) begin rd(a, r); chk("R2 limit", r, 0); end
        pad("R2 pad", 1'b0);

        // R3 limit read-back
        for (int a = 4; a < 12; a++) wr(a, 8'h10 + a);
        for (int a = 4; a < 12; a++) begin rd(a, r); chk("R3 readback", r, 8'h10 + a); end
        for (int a = 4; a < 12; a++) wr(a, 8'hFF);

        // Sweep: channel, axis, limit, value around limit
        for (int c = 0; c < NCH; c++) begin
            for (int ax = 0; ax < 2; ax++) begin
                for (int li = 0; li < 4; li++) begin
                    for (int dl = -1; dl <= 1; dl++) begin
                        int t;
                        int m;
                        bit hit;
                        logic [NCH*DW-1:0] mh;
                        logic [NCH*DW-1:0] mv;
                        t = lims[li];
                        m = t + dl;
                        if (m < 0 || m > 255) continue;
                        hit = (m < t);
                        wr(4 + 2 * c + ax, t);
                        wr(4 + 2 * c + (1 - ax), 0);
                        wr(0, 1 << c);
                        mh = '0; mv = '0;
                        if (ax == 0) begin
                            mh[c*DW +: DW] = DW'(m); mv[c*DW +: DW] = 8'hFF;
                        end else begin
                            mv[c*DW +: DW] = DW'(m); mh[c*DW +: DW] = 8'hFF;
                        end
                        pulse('1, mh, mv);
                        rd(1, r);
                        chk("R1/R4/R6 cause_h", r, (ax == 0 && hit) ? (1 << c) : 0);
                        rd(2, r);
                        chk("R1/R5/R6 cause_v", r, (ax == 1 && hit) ? (1 << c) : 0);
                        pad("R8 not yet", 1'b0);
                        @(negedge clk);
                        pad("R8 raised", hit);
                        if (hit) begin
                            wr(1 + ax, 0);
                            rd(1 + ax, r); chk("R7 zero write", r, 1 << c);
                            wr(1 + ax, 1 << c);
                            pad("R9 still driven", 1'b1);
                            @(negedge clk);
                            pad("R9 released", 1'b0);
                        end
                        wr(4 + 2 * c, 8'hFF);
                        wr(5 + 2 * c, 8'hFF);
                    end
                end
            end
        end

        // R10 set beats clear in the same cycle
        wr(0, 1);
        @(negedge clk);
        meas_valid = 4'b0001; meas_h = '0; meas_v = '0;
        reg_we = 1'b1; reg_addr = AW'(1); reg_wdata = 8'h01;
        @(negedge clk);
        meas_valid = '0; reg_we = 1'b0;
        rd(1, r); chk("R10 set wins", r, 1);
        rd(2, r); chk("R5 cause_v", r, 1);
        @(negedge clk);
        pad("R8 raised", 1'b1);

        // R7 per-register clear
        wr(1, 1);
        rd(1, r); chk("R7 cleared h", r, 0);
        rd(2, r); chk("R7 v untouched", r, 1);
        pad("R8 held by v", 1'b1);

        // R9 enable removal releases, bits persist
        wr(0, 0);
        pad("R9 still driven", 1'b1);
        @(negedge clk);
        pad("R9 released by enable", 1'b0);
        rd(2, r); chk("R9 sticky kept", r, 1);
        wr(0, 1);
        pad("R8 not yet", 1'b0);
        @(negedge clk);
        pad("R8 raised by enable", 1'b1);
        wr(2, 1);
        @(negedge clk);
        pad("R9 released", 1'b0);

        // Multi-channel: last bit rule, equality on vertical
        wr(0, 4'hF);
        pulse(4'b1010, '0, '1);
        rd(1, r); chk("R4 two channels", r, 8'h0A);
        rd(2, r); chk("R6 equal vertical", r, 0);
        @(negedge clk);
        pad("R8 raised", 1'b1);
        wr(1, 2);
        rd(1, r); chk("R7 partial clear", r, 8'h08);
        @(negedge clk);
        pad("R9 one left", 1'b1);
        wr(1, 8);
        pad("R9 still driven", 1'b1);
        @(negedge clk);
        pad("R9 released", 1'b0);

        // R4 no valid strobe
        pulse('0, '0, '0);
        rd(1, r); chk("R4 no valid", r, 0);
        rd(2, r); chk("R5 no valid", r, 0);

        // R12 unmapped addresses
        rd(3, r); chk("R12 read 3", r, 0);
        wr(3, 8'hAA);
        rd(3, r); chk("R12 read 3 after write", r, 0);
        wr(12, 8'h55);
        rd(12, r); chk("R12 read 12", r, 0);
        rd(0, r); chk("R12 enables unchanged", r, 4'hF);
        rd(4, r); chk("R12 limit unchanged", r, 8'hFF);
        rd(1, r); chk("R12 cause unchanged", r, 0);
        pad("R11 idle", 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule